// File: doc/BRIEF.md
# Flash Timing-Mode Negotiation Sequencer

This block runs once a NAND flash has been identified, and tries to move the interface to a fast asynchronous timing mode with extended data out. It picks the fastest usable mode the flash reports, either mode 5 or mode 4. It writes that mode into the flash's timing-mode feature. It then reads the feature back and moves to the faster timing only when the flash echoes the written value. On success it requests the matching controller clock rate and raises a sticky EDO-enabled flag. On any failure it signals `fail`, leaves the normal timing in place and returns to idle, so a later `start` is still accepted.

The sequencer does not drive the flash pins itself. Each step leaves as a byte request (command, address, write data or read data) on a valid/ready interface toward a NAND bus engine. Read results come back on a separate strobe. Chip select is held for the whole exchange. After each feature command the sequencer waits for the ready/busy line, with a guard delay and a timeout counter.

Top module: `onfi_mode_negotiator`

## Requirements
- R1: After reset, `chip_sel`, `bus_valid`, `edo_on`, `done` and `fail` are 0, and `clk_mhz` and `mode_q` are 0.
- R2: A `start` pulse is skipped when `onfi_ok` or `variant_ok` is low, or when neither bit 5 nor bit 4 of `mode_support` is set (bit k means mode k). In that case `done` pulses once, with no bus request, no `fail` and `chip_sel` left low.
- R3: The chosen mode is 5 when `mode_support[5]` is set, and otherwise 4.
- R4: The write phase issues, in order: command 0xEF (kind 0), address 0x01 (kind 1), then four data bytes (kind 2). The first data byte is the chosen mode and the other three are 0x00.
- R5: The read-back phase issues command 0xEE (kind 0), then address 0x01 (kind 1), then four read requests (kind 3, byte 0x00). Each read request completes when `rd_valid` returns a byte.
- R6: After the last write data byte and after the read-back address, no further request is issued until `rb_ready` is seen high. This happens at least GUARD cycles after entering the wait.
- R7: If `rb_ready` stays low for TIMEOUT cycles in a wait, the attempt ends. `done` and `fail` pulse together, `chip_sel` drops, and `edo_on` is unchanged.
- R8: If the first read-back byte differs from the chosen mode, the attempt ends with `done` and `fail` after the remaining reads, and `edo_on` is unchanged.
- R9: On a matching read-back, `done` pulses without `fail`, and `edo_on` becomes 1. `mode_q` takes the chosen mode, and `clk_mhz` becomes 100 for mode 5 or 80 for mode 4.
- R10: `chip_sel` is high whenever a request is offered and from the start of an exchange to its end. It is low once `done` pulses, on both outcomes.
- R11: An offered request holds `bus_valid`, `bus_kind` and `bus_byte` steady until it is accepted with `bus_ready`.
- R12: A failed attempt does not block later work: a new `start` without reset runs a full exchange, and a success sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: flash identified, try negotiation |
| onfi_ok | input | 1 | Flash supports the parameter-page/feature protocol |
| variant_ok | input | 1 | Controller variant supports the fast mode |
| mode_support | input | 6 | Asynchronous modes the flash reports, bit k = mode k |
| bus_valid | output | 1 | Byte request offered to the bus engine |
| bus_kind | output | 2 | 0 command, 1 address, 2 write data, 3 read data |
| bus_byte | output | 8 | Byte for command/address/write requests |
| bus_ready | input | 1 | Bus engine accepts the offered request |
| rd_valid | input | 1 | Read byte returned by the bus engine |
| rd_byte | input | 8 | Returned read data |
| rb_ready | input | 1 | Flash ready/busy line, high = ready |
| chip_sel | output | 1 | Chip select, active high |
| edo_on | output | 1 | Fast EDO timing enabled (sticky) |
| mode_q | output | 3 | Mode in force when `edo_on` is set |
| clk_mhz | output | 8 | Requested controller clock in MHz, 0 = none |
| done | output | 1 | One-cycle pulse at the end of every attempt |
| fail | output | 1 | One-cycle pulse with `done` on a failed attempt |

## Verification
The bench varies the reported mode mask so that both the mode 5 and mode 4 choices appear, along with masks holding only slow modes. A picker that took the lowest bit or ignored bit 5 would send the wrong first data byte and request the wrong clock. An echo that differs by one bit must fail the attempt, which catches a comparison made on the wrong byte or on too few bits. The bench also holds the ready/busy line low long enough to expire the timeout, and randomizes busy lengths and engine back-pressure. These catch a sequencer that runs on while the flash is busy, drops a held request, or leaves chip select asserted on the failure path. A retry after a failure, without reset, shows that failure leaves the block usable.

// File: rtl/tmn_pkg.sv
package tmn_pkg;
  typedef enum logic [1:0] {K_CMD = 2'd0, K_ADDR = 2'd1, K_WR = 2'd2, K_RD = 2'd3} bus_kind_e;
  typedef enum logic [2:0] {OP_CMD, OP_ADDR, OP_WR, OP_WAIT, OP_RD, OP_END} step_op_e;
  typedef struct packed {
    step_op_e   op;
    logic [7:0] val;
  } step_t;
  localparam logic [7:0] CMD_SET_FEAT = 8'hEF;
  localparam logic [7:0] CMD_GET_FEAT = 8'hEE;
  localparam logic [7:0] FEAT_TIMING  = 8'h01;
endpackage

// File: rtl/tmn_mode_pick.sv
module tmn_mode_pick #(
  parameter int NMODES   = 6,
  parameter int MIN_MODE = 4
) (
  input  logic [NMODES-1:0]         support,
  output logic                      found,
  output logic [$clog2(NMODES)-1:0] mode
);
  localparam int MW = $clog2(NMODES);
  always_comb begin
    mode  = '0;
    found = 1'b0;
    for (int k = 0; k < NMODES; k++) begin
      if (support[k]) begin
        mode  = MW'(k);
        found = (k >= MIN_MODE);
      end
    end
  end
endmodule

// File: rtl/tmn_step_rom.sv
module tmn_step_rom
  import tmn_pkg::*;
#(
  parameter int NPARAM = 4,
  parameter int SW     = 4
) (
  input  logic [SW-1:0] idx,
  input  logic [2:0]    mode,
  output step_t         step,
  output logic          is_check
);
  localparam int SET_WAIT = 2 + NPARAM;
  localparam int GET_CMD  = SET_WAIT + 1;
  localparam int GET_ADDR = SET_WAIT + 2;
  localparam int GET_WAIT = SET_WAIT + 3;
  localparam int RD_FIRST = SET_WAIT + 4;
  localparam int END_IDX  = RD_FIRST + NPARAM;

  always_comb begin
    step.op  = OP_END;
    step.val = 8'h00;
    if (int'(idx) == 0) begin
      step.op = OP_CMD;  step.val = CMD_SET_FEAT;
    end else if (int'(idx) == 1) begin
      step.op = OP_ADDR; step.val = FEAT_TIMING;
    end else if (int'(idx) < SET_WAIT) begin
      step.op  = OP_WR;
      step.val = (int'(idx) == 2) ? {5'b0, mode} : 8'h00;
    end else if (int'(idx) == SET_WAIT || int'(idx) == GET_WAIT) begin
      step.op = OP_WAIT;
    end else if (int'(idx) == GET_CMD) begin
      step.op = OP_CMD;  step.val = CMD_GET_FEAT;
    end else if (int'(idx) == GET_ADDR) begin
      step.op = OP_ADDR; step.val = FEAT_TIMING;
    end else if (int'(idx) < END_IDX) begin
      step.op = OP_RD;
    end
    is_check = (int'(idx) == RD_FIRST);
  end
endmodule

// File: rtl/tmn_wait_timer.sv
module tmn_wait_timer #(
  parameter int GUARD   = 2,
  parameter int TIMEOUT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic rb_ready,
  output logic seen,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)               cnt <= '0;
    else if (cnt != CW'(TIMEOUT))  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(TIMEOUT));
  assign seen    = run && (cnt >= CW'(GUARD)) && rb_ready;
endmodule

// File: rtl/onfi_mode_negotiator.sv
module onfi_mode_negotiator
  import tmn_pkg::*;
#(
  parameter int NPARAM   = 4,
  parameter int GUARD    = 2,
  parameter int TIMEOUT  = 1000,
  parameter int MHZ_HI   = 100,
  parameter int MHZ_LO   = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       onfi_ok,
  input  logic       variant_ok,
  input  logic [5:0] mode_support,
  output logic       bus_valid,
  output logic [1:0] bus_kind,
  output logic [7:0] bus_byte,
  input  logic       bus_ready,
  input  logic       rd_valid,
  input  logic [7:0] rd_byte,
  input  logic       rb_ready,
  output logic       chip_sel,
  output logic       edo_on,
  output logic [2:0] mode_q,
  output logic [7:0] clk_mhz,
  output logic       done,
  output logic       fail
);
  localparam int NSTEP = 2 * NPARAM + 7;
  localparam int SW    = $clog2(NSTEP);

  typedef enum logic {S_IDLE, S_RUN} state_e;
  state_e        state;
  logic [SW-1:0] step_idx;
  logic [2:0]    cur_mode;
  logic          rd_pend, mismatch;
  logic          pick_found;
  logic [2:0]    pick_mode;
  step_t         st;
  logic          st_check, wait_seen, wait_expired, wait_run;

  tmn_mode_pick #(.NMODES(6), .MIN_MODE(4)) u_pick (
    .support(mode_support), .found(pick_found), .mode(pick_mode));

  tmn_step_rom #(.NPARAM(NPARAM), .SW(SW)) u_rom (
    .idx(step_idx), .mode(cur_mode), .step(st), .is_check(st_check));

  assign wait_run = (state == S_RUN) && (st.op == OP_WAIT);

  tmn_wait_timer #(.GUARD(GUARD), .TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .run(wait_run), .rb_ready(rb_ready),
    .seen(wait_seen), .expired(wait_expired));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step_idx  <= '0;
      cur_mode  <= '0;
      rd_pend   <= 1'b0;
      mismatch  <= 1'b0;
      bus_valid <= 1'b0;
      bus_kind  <= K_CMD;
      bus_byte  <= 8'h00;
      chip_sel  <= 1'b0;
      edo_on    <= 1'b0;
      mode_q    <= '0;
      clk_mhz   <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (onfi_ok && variant_ok && pick_found) begin
              cur_mode <= pick_mode;
              chip_sel <= 1'b1;
              step_idx <= '0;
              mismatch <= 1'b0;
              rd_pend  <= 1'b0;
              state    <= S_RUN;
            end else begin
              done <= 1'b1;
            end
          end
        end
        default: begin
          case (st.op)
            OP_CMD, OP_ADDR, OP_WR: begin
              if (!bus_valid) begin
                bus_valid <= 1'b1;
                bus_byte  <= st.val;
                bus_kind  <= (st.op == OP_CMD)  ? K_CMD :
                             (st.op == OP_ADDR) ? K_ADDR : K_WR;
              end else if (bus_ready) begin
                bus_valid <= 1'b0;
                step_idx  <= step_idx + 1'b1;
              end
            end
            OP_WAIT: begin
              if (wait_expired) begin
                chip_sel <= 1'b0;
                done     <= 1'b1;
                fail     <= 1'b1;
                state    <= S_IDLE;
              end else if (wait_seen) begin
                step_idx <= step_idx + 1'b1;
              end
            end
            OP_RD: begin
              if (rd_pend) begin
                if (rd_valid) begin
                  rd_pend  <= 1'b0;
                  step_idx <= step_idx + 1'b1;
                  if (st_check && rd_byte != {5'b0, cur_mode}) mismatch <= 1'b1;
                end
              end else if (!bus_valid) begin
                bus_valid <= 1'b1;
                bus_kind  <= K_RD;
                bus_byte  <= 8'h00;
              end else if (bus_ready) begin
                bus_valid <= 1'b0;
                rd_pend   <= 1'b1;
              end
            end
            default: begin
              chip_sel <= 1'b0;
              done     <= 1'b1;
              state    <= S_IDLE;
              if (mismatch) begin
                fail <= 1'b1;
              end else begin
                edo_on  <= 1'b1;
                mode_q  <= cur_mode;
                clk_mhz <= (cur_mode == 3'd5) ? 8'(MHZ_HI) : 8'(MHZ_LO);
              end
            end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/tmn_checker.sv
module tmn_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_valid,
  input logic       bus_ready,
  input logic [1:0] bus_kind,
  input logic [7:0] bus_byte,
  input logic       chip_sel,
  input logic       edo_on,
  input logic [2:0] mode_q,
  input logic [7:0] clk_mhz,
  input logic       done,
  input logic       fail
);
  p_sel_on_request_r10: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> chip_sel);
  p_end_releases_sel_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !chip_sel);
  p_hold_offer_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_kind) && $stable(bus_byte)));
  p_fail_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);
  p_fail_keeps_flag_r8: assert property (@(posedge clk) disable iff (rst)
    fail |-> $stable(edo_on));
  p_flag_rate_match_r9: assert property (@(posedge clk) disable iff (rst)
    edo_on |-> ((mode_q == 3'd5 && clk_mhz == 8'd100) || (mode_q == 3'd4 && clk_mhz == 8'd80)));
  p_flag_rise_success_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(edo_on) |-> (done && !fail));
endmodule

bind onfi_mode_negotiator tmn_checker u_tmn_checker (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_kind(bus_kind), .bus_byte(bus_byte), .chip_sel(chip_sel),
  .edo_on(edo_on), .mode_q(mode_q), .clk_mhz(clk_mhz), .done(done), .fail(fail));

// File: tb/test_onfi_mode_negotiator.sv
`timescale 1ns/1ps
module test_onfi_mode_negotiator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, onfi_ok = 1'b0, variant_ok = 1'b0;
  logic [5:0] mode_support = '0;
  logic       bus_valid, bus_ready = 1'b1, rd_valid = 1'b0, rb_ready = 1'b1;
  logic [1:0] bus_kind;
  logic [7:0] bus_byte, rd_byte = 8'h00, clk_mhz;
  logic       chip_sel, edo_on, done, fail;
  logic [2:0] mode_q;

  always #2 clk = ~clk;

  onfi_mode_negotiator i_onfi_mode_negotiator (
    .clk(clk), .rst(rst), .start(start), .onfi_ok(onfi_ok), .variant_ok(variant_ok),
    .mode_support(mode_support), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_byte(bus_byte), .bus_ready(bus_ready), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .rb_ready(rb_ready), .chip_sel(chip_sel), .edo_on(edo_on), .mode_q(mode_q),
    .clk_mhz(clk_mhz), .done(done), .fail(fail));

  int n_checks = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // flash / bus engine model
  bit         rdy_rand = 0, stuck = 0;
  int         busy_len = 0, busy_cnt = 0;
  logic [7:0] echo_val = 0;
  bit         arm_busy = 0, arm_read = 0;
  int         nread = 0, ntx = 0, sel_viol = 0, busy_viol = 0;
  logic [1:0] tk [0:31];
  logic [7:0] tb_ [0:31];

  always @(negedge clk) begin
    if (rst) begin
      arm_busy = 0; arm_read = 0; rd_valid = 0; busy_cnt = 0;
    end else begin
      rd_valid = 1'b0;
      if (arm_read) begin
        rd_valid = 1'b1;
        rd_byte  = (nread == 0) ? echo_val : 8'($urandom);
        nread++;
        arm_read = 0;
      end
      if (arm_busy) begin
        arm_busy = 0;
        if (stuck || busy_len > 0) begin rb_ready = 1'b0; busy_cnt = busy_len; end
      end else if (!rb_ready && !stuck) begin
        if (busy_cnt <= 1) rb_ready = 1'b1; else busy_cnt--;
      end
      bus_ready = rdy_rand ? 1'($urandom) : 1'b1;
      if (bus_valid && bus_ready) begin
        if (ntx < 32) begin tk[ntx] = bus_kind; tb_[ntx] = bus_byte; end
        if (!chip_sel) sel_viol++;
        if (!rb_ready) busy_viol++;
        if (ntx == 5 || ntx == 7) arm_busy = 1;
        if (bus_kind == 2'd3) arm_read = 1;
        ntx++;
      end
    end
  end

  function automatic logic [1:0] exp_kind(input int i);
    if (i == 0 || i == 6) return 2'd0;
    if (i == 1 || i == 7) return 2'd1;
    if (i < 6) return 2'd2;
    return 2'd3;
  endfunction
  function automatic logic [7:0] exp_byte(input int i, input int m);
    case (i)
      0: return 8'hEF;
      6: return 8'hEE;
      1, 7: return 8'h01;
      2: return 8'(m);
      default: return 8'h00;
    endcase
  endfunction

  bit exp_edo = 0;
  int exp_mode = 0, exp_mhz = 0;

  task automatic do_reset();
    rst = 1'b1; rb_ready = 1'b1; stuck = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_edo = 0; exp_mode = 0; exp_mhz = 0;
  endtask

  task automatic run_case(input bit on, input bit va, input logic [5:0] mask,
                          input int blen, input bit stk, input bit bad_echo, input bit rr);
    bit elig, ok;
    int m, exp_n, cyc;
    elig = on && va && (mask[5] || mask[4]);
    m    = mask[5] ? 5 : 4;                                  // R3
    echo_val = bad_echo ? (8'(m) ^ (8'h01 << ($urandom % 8))) : 8'(m);
    ok   = elig && !stk && !bad_echo;
    exp_n = !elig ? 0 : (stk ? 6 : 12);
    busy_len = blen; stuck = stk; rdy_rand = rr; rb_ready = 1'b1;
    ntx = 0; nread = 0; sel_viol = 0; busy_viol = 0;
    onfi_ok = on; variant_ok = va; mode_support = mask;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R2", "attempt finished", int'(done), 1);
    if (ok) begin exp_edo = 1; exp_mode = m; exp_mhz = (m == 5) ? 100 : 80; end
    chk(fail === (elig && !ok), (stk ? "R7" : "R8"), "fail pulse", int'(fail), int'(elig && !ok));
    chk(edo_on === exp_edo, "R9", "edo flag", int'(edo_on), int'(exp_edo));
    if (exp_edo) begin
      chk(mode_q == 3'(exp_mode), "R9", "mode_q", int'(mode_q), exp_mode);
      chk(clk_mhz == 8'(exp_mhz), "R9", "clock request", int'(clk_mhz), exp_mhz);
    end
    chk(chip_sel === 1'b0, "R10", "chip select released", int'(chip_sel), 0);
    chk(ntx == exp_n, "R2", "request count", ntx, exp_n);
    chk(sel_viol == 0, "R10", "requests without chip select", sel_viol, 0);
    chk(busy_viol == 0, "R6", "requests while busy", busy_viol, 0);
    for (int i = 0; i < exp_n && i < ntx; i++) begin
      chk(tk[i] == exp_kind(i), (i < 6) ? "R4" : "R5", "request kind", int'(tk[i]), int'(exp_kind(i)));
      chk(tb_[i] == exp_byte(i, m), (i < 6) ? "R4" : "R5", "request byte", int'(tb_[i]), int'(exp_byte(i, m)));
    end
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk(chip_sel === 0 && bus_valid === 0, "R1", "idle bus after reset", int'(chip_sel), 0);
    chk(edo_on === 0 && clk_mhz == 0 && mode_q == 0, "R1", "flag/rate after reset", int'(clk_mhz), 0);
    chk(done === 0 && fail === 0, "R1", "no pulse after reset", int'(done), 0);
    // directed
    run_case(1, 1, 6'b110000, 3, 0, 0, 0);   // mode 5 success
    do_reset(); run_case(1, 1, 6'b011111, 0, 0, 0, 1);  // mode 4, back-pressure
    do_reset(); run_case(0, 1, 6'b110000, 2, 0, 0, 0);  // R2 not capable
    run_case(1, 0, 6'b110000, 2, 0, 0, 0);              // R2 wrong variant
    run_case(1, 1, 6'b001111, 2, 0, 0, 0);              // R2 slow modes only
    do_reset(); run_case(1, 1, 6'b100000, 2, 1, 0, 0);  // R7 timeout
    run_case(1, 1, 6'b010000, 4, 0, 1, 1);              // R8 bad echo, no reset
    run_case(1, 1, 6'b010000, 4, 0, 0, 1);              // R12 retry succeeds
    run_case(1, 1, 6'b110000, 4, 0, 1, 0);              // R8 flag kept after fail
    // random
    void'($urandom(32'd1234));
    for (int n = 0; n < 30; n++) begin
      if ($urandom % 3 == 0) do_reset();
      run_case(($urandom % 6) != 0, ($urandom % 6) != 0, 6'($urandom),
               $urandom % 9, ($urandom % 10) == 0, ($urandom % 4) == 0, 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule